// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Unit

This unit sits between a radio datapath and the host register bank. It takes single-cycle event pulses from the datapath and keeps each one in a status bit that stays set until the host clears it. The events are packet received, transmit done, CRC error, acknowledgment timeout, FIFO overflow, FIFO underflow, channel busy, link lost and a received-signal-strength event. The host reads one status word to find every pending source. The host clears bits by writing ones to them.

A per-source enable word decides which pending sources may raise the interrupt line. The line is edge-style: it pulses for one cycle when an enabled source becomes pending, and it stays low while that source stays pending. The signal-strength source is not a datapath pulse. The unit derives it by comparing each valid measurement against a threshold the host can program.

A saturating counter tracks how many packet errors have occurred in a row. Software can read it to decide when to change channel or lower the data rate. Any successful packet returns the counter to zero.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, the status word reads 0, every source is disabled for interrupts, the error run counter reads 0, the interrupt line is low, and the RSSI threshold is all ones, so no measurement can exceed it.
- R2: A status bit that is set stays set in every later cycle until a clear write has a 1 in that bit position.
- R3: If a source's event pulse arrives in the same cycle as a clear write with a 1 in that bit, the bit is set after that edge.
- R4: A clear write (clr_we_i high) clears exactly the status bits where clr_data_i holds 1 and there is no event that cycle; bits written 0 keep their value.
- R5: An event on a source whose enable bit is 0 still sets its status bit but does not raise irq_o.
- R6: irq_o is high for exactly one cycle, in the first cycle an enabled status bit reads set after having been clear (or disabled). It does not rise again while that bit stays set and enabled.
- R7: Writing an enable bit to 1 for a source whose status bit is already set produces one irq_o pulse, in the cycle after the write edge.
- R8: Status bit 8 (RSSI) sets only when rssi_valid_i is high and rssi_level_i is strictly greater than the threshold. A level equal to the threshold does not set it.
- R9: A threshold write with thr_we_i takes effect for the measurements sampled at the next and later clock edges.
- R10: The error run counter increments by 1 on a cycle with a CRC error (evt bit 2) or an acknowledgment timeout (evt bit 3). It returns to 0 on a cycle with packet received (evt bit 0) or transmit done (evt bit 1), and a success in the same cycle as an error wins.
- R11: The error run counter stops at 2^ERR_CNT_W-1 (15 by default) and stays there on further errors.
- R12: The status word places the sources at these bit positions: 0 packet received, 1 transmit done, 2 CRC error, 3 acknowledgment timeout, 4 FIFO overflow, 5 FIFO underflow, 6 channel busy, 7 link lost (evt_i bits 0..7 in the same order), 8 RSSI above threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Single-cycle datapath event pulses, bit order as in R12 |
| rssi_valid_i | input | 1 | rssi_level_i carries a new measurement this cycle |
| rssi_level_i | input | RSSI_W (8) | Measured signal level |
| clr_we_i | input | 1 | Write strobe for the write-one-to-clear word |
| clr_data_i | input | 9 | Status bits to clear |
| en_we_i | input | 1 | Write strobe for the interrupt enable word |
| en_data_i | input | 9 | New interrupt enable word, 1 = source may interrupt |
| thr_we_i | input | 1 | Write strobe for the RSSI threshold |
| thr_data_i | input | RSSI_W (8) | New RSSI threshold |
| status_o | output | 9 | Sticky status word |
| err_run_o | output | ERR_CNT_W (4) | Consecutive packet error count |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A lost or stray status bit shows up on status_o one cycle after the edge that should, or should not, have set it. A stale copy of the pending set in the edge detector shows up as a missing or extra irq_o pulse in that same cycle. A wrong threshold or counter value appears on the RSSI status bit or on err_run_o after the next measurement or packet event. The bench therefore compares all three outputs against a behavioural model in every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
   localparam int SRC_RX_OK    = 0;
   localparam int SRC_TX_DONE  = 1;
   localparam int SRC_CRC_ERR  = 2;
   localparam int SRC_ACK_TO   = 3;
   localparam int SRC_FIFO_OVF = 4;
   localparam int SRC_FIFO_UNF = 5;
   localparam int SRC_CH_BUSY  = 6;
   localparam int SRC_LINK_LOST= 7;
   localparam int SRC_RSSI     = 8;
   localparam int NUM_DP_EVT   = 8;
   localparam int NUM_SRC      = NUM_DP_EVT + 1;
endpackage

// File: rtl/status_latch.sv
module status_latch #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("status_latch: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[b] <= 1'b0;
         else        q_o[b] <= set_i[b] | (q_o[b] & ~clr_i[b]);
      end

      // R2: held until cleared
      p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[b] && !clr_i[b]) |=> q_o[b]);
      // R3: event beats clear
      p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q_o[b]);
      // R4: write-one-to-clear
      p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !q_o[b]);
   end
endmodule

// File: rtl/rssi_cmp.sv
module rssi_cmp #(
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          thr_we_i,
   input  logic [RW-1:0] thr_data_i,
   input  logic          valid_i,
   input  logic [RW-1:0] level_i,
   output logic          hit_o,
   output logic [RW-1:0] thr_o
);
   localparam logic [RW-1:0] THR_RESET = '1;

   if (RW < 1 || RW > 16) begin : g_bad_rw
      $error("rssi_cmp: RW must lie in 1..16");
   end

   logic [RW-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thr_q <= THR_RESET;
      else if (thr_we_i) thr_q <= thr_data_i;
   end

   assign hit_o = valid_i && (level_i > thr_q);
   assign thr_o = thr_q;

   // R9: threshold loads on write
   p_thr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      thr_we_i |=> (thr_q == $past(thr_data_i)));
endmodule

// File: rtl/err_run_counter.sv
module err_run_counter #(
   parameter int CW       = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   if (CW < 2) begin : g_bad_cw
      $error("err_run_counter: CW must be at least 2");
   end

   logic [CW-1:0] step_val;

   if (SATURATE) begin : g_sat
      assign step_val = (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + 1'b1;
      // R11: sticks at maximum
      p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
         ((cnt_o == CNT_MAX) && !clr_i) |=> (cnt_o == CNT_MAX));
   end else begin : g_wrap
      assign step_val = cnt_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= step_val;
   end

   // R10: success returns the run to zero
   p_success_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/irq_edge_gen.sv
module irq_edge_gen #(
   parameter int W       = 9,
   parameter bit OUT_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic [W-1:0] pend;
   logic [W-1:0] pend_q;
   logic         rise_any;

   assign pend     = status_i & en_i;
   assign rise_any = |(pend & ~pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend;
   end

   if (OUT_REG) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= rise_any;
      end
      assign irq_o = irq_q;
   end else begin : g_comb_out
      assign irq_o = rise_any;
   end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
   import irq_status_pkg::*;
#(
   parameter int RSSI_W       = 8,
   parameter int ERR_CNT_W    = 4,
   parameter bit ERR_SATURATE = 1'b1,
   parameter bit IRQ_OUT_REG  = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_DP_EVT-1:0] evt_i,
   input  logic                  rssi_valid_i,
   input  logic [RSSI_W-1:0]     rssi_level_i,
   input  logic                  clr_we_i,
   input  logic [NUM_SRC-1:0]    clr_data_i,
   input  logic                  en_we_i,
   input  logic [NUM_SRC-1:0]    en_data_i,
   input  logic                  thr_we_i,
   input  logic [RSSI_W-1:0]     thr_data_i,
   output logic [NUM_SRC-1:0]    status_o,
   output logic [ERR_CNT_W-1:0]  err_run_o,
   output logic                  irq_o
);
   if (NUM_SRC != NUM_DP_EVT + 1) begin : g_bad_src
      $error("irq_status_hub: source count mismatch");
   end

   logic               rssi_hit;
   logic [RSSI_W-1:0]  thr_cur;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] en_q;
   logic               pkt_ok;
   logic               pkt_err;

   rssi_cmp #(.RW(RSSI_W)) u_rssi (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_we_i   (thr_we_i),
      .thr_data_i (thr_data_i),
      .valid_i    (rssi_valid_i),
      .level_i    (rssi_level_i),
      .hit_o      (rssi_hit),
      .thr_o      (thr_cur)
   );

   assign set_vec = {rssi_hit, evt_i};
   assign clr_vec = clr_we_i ? clr_data_i : '0;

   status_latch #(.W(NUM_SRC)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .q_o   (status_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_we_i) en_q <= en_data_i;
   end

   irq_edge_gen #(.W(NUM_SRC), .OUT_REG(IRQ_OUT_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_o),
      .en_i     (en_q),
      .irq_o    (irq_o)
   );

   assign pkt_ok  = evt_i[SRC_RX_OK] | evt_i[SRC_TX_DONE];
   assign pkt_err = evt_i[SRC_CRC_ERR] | evt_i[SRC_ACK_TO];

   err_run_counter #(.CW(ERR_CNT_W), .SATURATE(ERR_SATURATE)) u_errcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (pkt_err),
      .clr_i (pkt_ok),
      .cnt_o (err_run_o)
   );

   // R5: nothing pending and enabled means no interrupt
   p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & en_q) == '0) |-> !irq_o);

   if (!IRQ_OUT_REG) begin : g_irq_chk
      // R6: no pulse without a change in status or enables
      p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($stable(status_o) && $stable(en_q)) |-> !irq_o);
   end

   // R8: RSSI bit only rises after a valid level above threshold
   p_rssi_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[SRC_RSSI]) |-> $past(rssi_valid_i && (rssi_level_i > thr_cur)));
endmodule

// File: tb/irq_status_hub_test.sv
module irq_status_hub_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt = '0;
   logic       rv = 1'b0;
   logic [7:0] lvl = '0;
   logic       cwe = 1'b0;
   logic [8:0] cd = '0;
   logic       ewe = 1'b0;
   logic [8:0] ed = '0;
   logic       twe = 1'b0;
   logic [7:0] td = '0;
   logic [8:0] status;
   logic [3:0] errcnt;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   logic [8:0] m_st, m_en, m_prev;
   logic [7:0] m_thr;
   int         m_cnt;

   always #2 clk = ~clk;

   irq_status_hub uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .rssi_valid_i(rv), .rssi_level_i(lvl),
      .clr_we_i(cwe), .clr_data_i(cd), .en_we_i(ewe), .en_data_i(ed),
      .thr_we_i(twe), .thr_data_i(td), .status_o(status), .err_run_o(errcnt), .irq_o(irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = '0; m_en = '0; m_prev = '0; m_thr = 8'hFF; m_cnt = 0;
      end else begin
         logic hit;
         m_prev = m_st & m_en;
         hit = rv && (lvl > m_thr);
         if (cwe) m_st = m_st & ~cd;
         m_st = m_st | {hit, evt};
         if (ewe) m_en = ed;
         if (twe) m_thr = td;
         if (evt[0] || evt[1]) m_cnt = 0;
         else if ((evt[2] || evt[3]) && m_cnt < 15) m_cnt = m_cnt + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R12 status word vs model", int'(status), int'(m_st));
         chk("R6 irq vs model", int'(irq), int'(|((m_st & m_en) & ~m_prev)));
         chk("R10 error run vs model", int'(errcnt), m_cnt);
      end
   end

   task automatic idle_inputs();
      evt = '0; rv = 1'b0; lvl = '0; cwe = 1'b0; cd = '0;
      ewe = 1'b0; ed = '0; twe = 1'b0; td = '0;
   endtask

   // inputs are set by caller at a negedge; one clock edge then back to the negedge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 status after reset", int'(status), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 counter after reset", int'(errcnt), 0);
      rv = 1'b1; lvl = 8'hFF; step();
      chk("R1 threshold all ones blocks RSSI", int'(status), 0);

      ewe = 1'b1; ed = 9'h1FF; step();
      evt = 8'h04; step();
      chk("R6 first set gives irq", int'(irq), 1);
      chk("R12 CRC error at bit 2", int'(status), 9'h004);
      chk("R10 counter after one error", int'(errcnt), 1);
      step();
      chk("R2 bit held", int'(status), 9'h004);
      chk("R6 no repeat pulse", int'(irq), 0);

      evt = 8'h04; cwe = 1'b1; cd = 9'h004; step();
      chk("R3 event beats clear", int'(status), 9'h004);
      chk("R10 counter after two errors", int'(errcnt), 2);
      cwe = 1'b1; cd = 9'h000; step();
      chk("R4 zero write keeps bit", int'(status), 9'h004);
      cwe = 1'b1; cd = 9'h004; step();
      chk("R4 one write clears bit", int'(status), 0);

      ewe = 1'b1; ed = 9'h07F; step();
      evt = 8'h80; step();
      chk("R5 masked source latches", int'(status), 9'h080);
      chk("R5 masked source no irq", int'(irq), 0);
      ewe = 1'b1; ed = 9'h1FF; step();
      chk("R7 unmask pending gives pulse", int'(irq), 1);
      step();
      chk("R7 single pulse only", int'(irq), 0);
      cwe = 1'b1; cd = 9'h1FF; step();

      twe = 1'b1; td = 8'd100; step();
      rv = 1'b1; lvl = 8'd100; step();
      chk("R8 equal level ignored", int'(status), 0);
      rv = 1'b0; lvl = 8'd101; step();
      chk("R8 invalid sample ignored", int'(status), 0);
      rv = 1'b1; lvl = 8'd101; step();
      chk("R9 programmed threshold exceeded", int'(status), 9'h100);
      chk("R6 RSSI pulse", int'(irq), 1);

      evt = 8'h01; step();
      chk("R10 success resets counter", int'(errcnt), 0);
      for (int i = 0; i < 20; i++) begin
         evt = 8'h08; step();
      end
      chk("R11 counter saturates", int'(errcnt), 15);
      evt = 8'h05; step();
      chk("R10 success wins over error", int'(errcnt), 0);

      cwe = 1'b1; cd = 9'h1FF; step();
      evt = 8'hFF; rv = 1'b1; lvl = 8'd200; step();
      chk("R12 all sources visible", int'(status), 9'h1FF);

      // random traffic, compared every cycle against the model
      for (int i = 0; i < 2000; i++) begin
         evt = 8'($urandom & $urandom & $urandom);
         rv  = 1'($urandom);
         lvl = 8'($urandom);
         cwe = ($urandom % 4) == 0;
         cd  = 9'($urandom);
         ewe = ($urandom % 8) == 0;
         ed  = 9'($urandom);
         twe = ($urandom % 16) == 0;
         td  = 8'($urandom);
         step();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule